// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address of each beat of a short wrapping burst. When a new external address is strobed, the block captures it. The low bits become the start offset and the beat count returns to zero. Each rising clock edge on which the active-low advance input is low moves the burst to its next beat. The low address bits then follow one of two orders, chosen by a mode input.

- **Interleaved order** (mode high): the beat count is XORed onto the start offset.
- **Linear order** (mode low): the beat count is added to the start offset, modulo the burst length.

The upper address bits are held at their captured value for the whole burst. With the default two-bit counter a burst has four beats and then wraps.

The sequencer sits in front of a memory array and drives its address. The same stepping serves read bursts and write bursts. It never touches the array and never decides the direction of a transfer.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released with no load, `addr_o` is all zeros and `beat_o` is 0.
- R2: A clock edge with `load_i` high captures `addr_i`. After that edge `addr_o` equals the captured address and `beat_o` is 0. This holds even in the middle of a burst.
- R3: When `load_i` and an advance request (`adv_n_i` low) meet at the same edge, the load wins. After the edge `beat_o` is 0 and `addr_o` equals `addr_i`.
- R4: A clock edge with `load_i` low and `adv_n_i` low increments `beat_o` by one, modulo 2^BEAT_W. The step after the last beat brings `beat_o` back to 0 and the low bits back to the start offset.
- R5: A clock edge with `load_i` low and `adv_n_i` high leaves `beat_o` and `addr_o` unchanged.
- R6: With `mode_i` = 1 (interleaved), the low BEAT_W bits of `addr_o` equal the start offset XOR `beat_o`. For example, start 01 gives the order 01, 00, 11, 10.
- R7: With `mode_i` = 0 (linear), the low BEAT_W bits of `addr_o` equal the start offset plus `beat_o`, modulo 2^BEAT_W. For example, start 10 gives the order 10, 11, 00, 01.
- R8: Bits `addr_o[ADDR_W-1:BEAT_W]` equal the same bits of the last captured address. Advancing never changes them.
- R9: `mode_i` acts combinationally on the low address bits. Changing it alters `addr_o` in the same cycle without changing `beat_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | New-address strobe, active high |
| addr_i | input | ADDR_W | External start address |
| adv_n_i | input | 1 | Advance request, active low |
| mode_i | input | 1 | Order select: 1 interleaved, 0 linear |
| addr_o | output | ADDR_W | Address of the current beat |
| beat_o | output | BEAT_W | Index of the current beat |

## Verification
The checker watches every cycle for the following:
- a load clearing the beat and reproducing the strobed address, with priority over an advance;
- an advance stepping the beat by exactly one;
- a held request freezing the state;
- the upper bits staying put;
- with the mode held steady, each step moving the low bits by one in linear order, or by the same XOR pattern as the beat change in interleaved order.

Only the bench's scenarios can show that the complete sequences from every start offset match the listed orders in both modes. They also show the wrap back to the start after the last beat, a reload cutting into a running burst, and a mode change taking effect within the cycle.

// File: rtl/burst_pkg.sv
package burst_pkg;

   // Order codes carried on the mode input.
   localparam logic ORD_LINEAR = 1'b0;
   localparam logic ORD_INTLV  = 1'b1;

   // Smallest legal counter width and upper address bit budget.
   localparam int unsigned MIN_BEAT_W  = 1;
   localparam int unsigned MIN_UPPER_W = 1;

endpackage

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned BEAT_W = 2,
   localparam int unsigned UPPER_W = ADDR_W - BEAT_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic [ADDR_W-1:0]  addr_i,
   output logic [BEAT_W-1:0]  start_o,
   output logic [UPPER_W-1:0] upper_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_o <= '0;
         upper_o <= '0;
      end else if (load_i) begin
         start_o <= addr_i[BEAT_W-1:0];
         upper_o <= addr_i[ADDR_W-1:BEAT_W];
      end
   end

endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt #(
   parameter int unsigned BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              step_i,
   output logic [BEAT_W-1:0] beat_o
);

   logic [BEAT_W-1:0] beat_nxt;

   // Ripple incrementer built bit by bit; the carry out of the top bit is dropped so the count wraps.
   logic [BEAT_W:0] carry;
   assign carry[0] = 1'b1;

   for (genvar b = 0; b < BEAT_W; b++) begin : g_inc
      assign beat_nxt[b]  = beat_o[b] ^ carry[b];
      assign carry[b + 1] = beat_o[b] & carry[b];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat_o <= '0;
      end else if (clr_i) begin
         beat_o <= '0;
      end else if (step_i) begin
         beat_o <= beat_nxt;
      end
   end

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
   parameter int unsigned BEAT_W = 2
) (
   input  logic              mode_i,
   input  logic [BEAT_W-1:0] start_i,
   input  logic [BEAT_W-1:0] beat_i,
   output logic [BEAT_W-1:0] low_o
);

   import burst_pkg::*;

   logic [BEAT_W-1:0] xor_val;
   logic [BEAT_W-1:0] sum_val;
   logic [BEAT_W:0]   cy;

   assign cy[0] = 1'b0;

   for (genvar b = 0; b < BEAT_W; b++) begin : g_bit
      assign xor_val[b] = start_i[b] ^ beat_i[b];
      assign sum_val[b] = xor_val[b] ^ cy[b];
      assign cy[b + 1]  = (start_i[b] & beat_i[b]) | (xor_val[b] & cy[b]);
   end

   always_comb begin
      if (mode_i == ORD_INTLV) low_o = xor_val;
      else                     low_o = sum_val;
   end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              adv_n_i,
   input  logic              mode_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [BEAT_W-1:0] beat_o
);

   import burst_pkg::*;

   localparam int unsigned UPPER_W = ADDR_W - BEAT_W;

   if (BEAT_W < MIN_BEAT_W) begin : g_bad_beat
      $error("burst_addr_gen: BEAT_W must be at least %0d", MIN_BEAT_W);
   end
   if (ADDR_W < BEAT_W + MIN_UPPER_W) begin : g_bad_addr
      $error("burst_addr_gen: ADDR_W must exceed BEAT_W");
   end

   logic [BEAT_W-1:0]  start_q;
   logic [UPPER_W-1:0] upper_q;
   logic [BEAT_W-1:0]  low_w;
   logic               step_w;

   // A load takes priority over an advance at the same edge.
   assign step_w = ~adv_n_i & ~load_i;

   burst_start_reg #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) i_start (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load_i),
      .addr_i  (addr_i),
      .start_o (start_q),
      .upper_o (upper_q)
   );

   burst_beat_cnt #(.BEAT_W(BEAT_W)) i_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (load_i),
      .step_i (step_w),
      .beat_o (beat_o)
   );

   burst_order_map #(.BEAT_W(BEAT_W)) i_map (
      .mode_i  (mode_i),
      .start_i (start_q),
      .beat_i  (beat_o),
      .low_o   (low_w)
   );

   assign addr_o = {upper_q, low_w};

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned BEAT_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic              adv_n_i,
   input logic              mode_i,
   input logic [ADDR_W-1:0] addr_o,
   input logic [BEAT_W-1:0] beat_o
);

   // R2: a load reproduces the address and clears the beat
   assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (addr_o == $past(addr_i)) && (beat_o == '0));

   // R3: a load wins over a simultaneous advance
   assert_load_priority_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !adv_n_i) |=> (beat_o == '0));

   // R4: an advance steps the beat by exactly one, modulo the burst length
   assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !adv_n_i) |=> (beat_o == BEAT_W'($past(beat_o) + 1'b1)));

   // R5: no load and no advance means the state is frozen
   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && adv_n_i) |=> $stable(beat_o));

   // R6: with interleaved order held, the low bits change by the same XOR pattern as the beat
   assert_intlv_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !adv_n_i && mode_i) |=>
         (!mode_i || ((addr_o[BEAT_W-1:0] ^ $past(addr_o[BEAT_W-1:0])) == (beat_o ^ $past(beat_o)))));

   // R7: with linear order held, the low bits move up by one
   assert_linear_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !adv_n_i && !mode_i) |=>
         (mode_i || (addr_o[BEAT_W-1:0] == BEAT_W'($past(addr_o[BEAT_W-1:0]) + 1'b1))));

   // R8: upper address bits change only through a load
   assert_upper_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(addr_o[ADDR_W-1:BEAT_W]));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .load_i  (load_i),
   .addr_i  (addr_i),
   .adv_n_i (adv_n_i),
   .mode_i  (mode_i),
   .addr_o  (addr_o),
   .beat_o  (beat_o)
);

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;

   localparam int ADDR_W = 32;
   localparam int BEAT_W = 2;
   localparam time CLK_PERIOD = 10ns;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              load_i = 1'b0;
   logic [ADDR_W-1:0] addr_i = '0;
   logic              adv_n_i = 1'b1;
   logic              mode_i = 1'b1;
   logic [ADDR_W-1:0] addr_o;
   logic [BEAT_W-1:0] beat_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   burst_addr_gen #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) i_burst_addr_gen (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load_i),
      .addr_i  (addr_i),
      .adv_n_i (adv_n_i),
      .mode_i  (mode_i),
      .addr_o  (addr_o),
      .beat_o  (beat_o)
   );

   // Expected low bits from R6 (XOR) and R7 (add modulo 4).
   function automatic logic [1:0] exp_low(input logic [1:0] s, input logic [1:0] b, input logic m);
      return m ? (s ^ b) : 2'(s + b);
   endfunction

   task automatic chk(input string req, input logic [ADDR_W-1:0] ea, input logic [BEAT_W-1:0] eb);
      checks++;
      if (addr_o !== ea || beat_o !== eb) begin
         errors++;
         $display("FAIL %s: addr=%h beat=%0d, expected addr=%h beat=%0d", req, addr_o, beat_o, ea, eb);
      end
   endtask

   // Drive at the falling edge, then sample just after the next rising edge.
   task automatic cyc(input logic ld, input logic [ADDR_W-1:0] a, input logic advn);
      @(negedge clk);
      load_i  = ld;
      addr_i  = a;
      adv_n_i = advn;
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      #3;
      chk("R1 in reset", '0, '0);
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      cyc(1'b0, '0, 1'b1);
      chk("R1 after release", '0, '0);
   endtask

   // R4, R6, R7, R8: every start offset, full burst and wrap, in the given order
   task automatic t_walk(input logic m);
      @(negedge clk);
      mode_i = m;
      for (int s = 0; s < 4; s++) begin
         logic [ADDR_W-1:0] base;
         base = 32'hA5C3_1F00 ^ (s << 8);
         cyc(1'b1, base | ADDR_W'(s), 1'b1);
         chk(m ? "R6 start" : "R7 start", base | ADDR_W'(exp_low(2'(s), 2'd0, m)), 2'd0);
         for (int b = 1; b < 5; b++) begin
            cyc(1'b0, 32'hFFFF_FFFF, 1'b0);
            chk(b == 4 ? "R4 wrap" : (m ? "R6 R8 step" : "R7 R8 step"),
                base | ADDR_W'(exp_low(2'(s), 2'(b), m)), 2'(b));
         end
      end
   endtask

   task automatic t_hold();
      @(negedge clk);
      mode_i = 1'b0;
      cyc(1'b1, 32'h1234_5672, 1'b1);
      cyc(1'b0, '0, 1'b0);
      cyc(1'b0, 32'hDEAD_BEEF, 1'b1);
      chk("R5 hold 1", 32'h1234_5673, 2'd1);
      cyc(1'b0, 32'h0, 1'b1);
      chk("R5 hold 2", 32'h1234_5673, 2'd1);
   endtask

   task automatic t_reload_mid();
      @(negedge clk);
      mode_i = 1'b1;
      cyc(1'b1, 32'h0000_0F01, 1'b1);
      cyc(1'b0, '0, 1'b0);
      cyc(1'b0, '0, 1'b0);
      chk("R6 mid burst", 32'h0000_0F03, 2'd2);
      cyc(1'b1, 32'h7777_0002, 1'b1);
      chk("R2 reload mid burst", 32'h7777_0002, 2'd0);
      cyc(1'b0, '0, 1'b0);
      chk("R6 after reload", 32'h7777_0003, 2'd1);
   endtask

   task automatic t_load_priority();
      @(negedge clk);
      mode_i = 1'b0;
      cyc(1'b1, 32'h0101_0100, 1'b1);
      cyc(1'b0, '0, 1'b0);
      cyc(1'b1, 32'h2222_3331, 1'b0);
      chk("R3 load beats advance", 32'h2222_3331, 2'd0);
   endtask

   task automatic t_mode_switch();
      @(negedge clk);
      mode_i = 1'b1;
      cyc(1'b1, 32'h0000_4441, 1'b1);
      cyc(1'b0, '0, 1'b0);
      chk("R9 interleaved beat1", 32'h0000_4440, 2'd1);
      @(negedge clk);
      mode_i = 1'b0;
      adv_n_i = 1'b1;
      #1;
      chk("R9 linear same cycle", 32'h0000_4442, 2'd1);
   endtask

   initial begin
      t_reset();
      t_walk(1'b1);
      t_walk(1'b0);
      t_hold();
      t_reload_mid();
      t_load_priority();
      t_mode_switch();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run hung, actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule